// File: doc/BRIEF.md
# Multi-Mode Prescaled Down-Counter Timer

This block is an 8-bit timer built from a programmable prescaler and a main down-counter. Each count pulse decrements the counter. A pulse that arrives while the counter holds 0x01 reloads it from the data register instead, emits a one-cycle time-out strobe and toggles the timer output. Count pulses come from one of three sources, chosen by the control register. In delay mode they come from the prescaler, which divides the block clock. In pulse-width mode they come from the prescaler, but it runs only while the auxiliary input sits at its active level. In event-count mode each active edge of the auxiliary input is one count pulse.

The auxiliary input is synchronised inside the block. It also drives an auxiliary event strobe. In pulse-width mode this strobe marks the edge that ends the active level, and in every other mode it marks the edge that starts it. An input that changes at most once every four clocks is counted reliably. The live counter value is always visible on a readback port. Loading the data register while the timer is stopped also loads the counter. Loading it while the timer runs only changes the value used at the next reload.

Top module: `ptimer`

## Requirements
- R1: A count pulse that finds the counter at 0x01 reloads it from the data register and raises `timeout_o` for exactly one clock.
- R2: With a data value N of 1 to 255 the time-out recurs every N count pulses, and with a data value of 0x00 it recurs every 256 count pulses.
- R3: Each time-out toggles `tmr_out`. Reset drives `tmr_out` low. A control write with `cfg_wdata[5]`=1 forces `tmr_out` low, and this takes precedence over a time-out in the same clock.
- R4: The control field `cfg_wdata[3:0]` selects the mode: 0 is stopped, 8 is event count, 1 to 7 are delay mode and 9 to 15 are pulse-width mode. In both prescaled modes the low three bits pick a divisor: 1:4, 2:10, 3:16, 4:50, 5:64, 6:100, 7:200. After a control write the prescaler restarts, so with divisor 10 and data 100 the time-outs fall exactly 1000, 2000 and 3000 clocks after the write.
- R5: In pulse-width mode the prescaler advances only while the synchronised auxiliary input equals the polarity bit `cfg_wdata[4]` (1 = active high). It holds its value while the input is inactive. `aux_evt_o` pulses once on the edge that ends the active level, and not on the edge that starts it.
- R6: In event-count mode each edge of the auxiliary input into its active level (rising when the polarity bit is 1, falling when it is 0) is one count pulse, and `aux_evt_o` pulses on that same edge. Edges in the other direction neither count nor strobe.
- R7: A data write while the timer is stopped loads both the data register and the counter. A data write while it runs leaves the current count unchanged, and the new value is used at the next reload.
- R8: Reset stops the timer (control field returns to 0) and clears neither the data register nor the counter value.
- R9: `cnt_o` shows the live counter value at all times.
- R10: With the control field at 0 no count pulses occur: the counter holds and no time-out is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 6 | [3:0] mode field, [4] auxiliary polarity, [5] output clear |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | CNT_W | Reload value |
| aux_in | input | 1 | Asynchronous auxiliary input |
| cnt_o | output | CNT_W | Live main-counter value |
| tmr_out | output | 1 | Output toggled by each time-out |
| timeout_o | output | 1 | One-clock time-out strobe |
| aux_evt_o | output | 1 | Auxiliary edge strobe |

## Verification
The hardest case to reach from the ports is a pulse-width window that ends partway through a prescale period. The count that results depends on the synchroniser delay at both ends of the window and on the prescaler keeping its partial progress. The bench holds the auxiliary input active for exactly 30 clocks with divisor 4 and a load of 10. It expects exactly seven decrements, one auxiliary strobe at the end of the window and none at its start. It also checks that the count does not move afterwards. A reload written in the middle of a running period is checked against the time-out cycle numbers held in the scoreboard queue.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    typedef enum logic [1:0] {
        MD_STOP  = 2'd0,
        MD_DELAY = 2'd1,
        MD_EVENT = 2'd2,
        MD_PULSE = 2'd3
    } mode_e;

    typedef struct packed {
        logic [3:0] field;
        logic       pol;
    } ctrl_t;

    function automatic mode_e decode_mode(input logic [3:0] f);
        if (f == 4'd0)      return MD_STOP;
        else if (f == 4'd8) return MD_EVENT;
        else if (f[3])      return MD_PULSE;
        else                return MD_DELAY;
    endfunction

    function automatic logic [7:0] prescale_div(input logic [2:0] s);
        case (s)
            3'd1:    return 8'd4;
            3'd2:    return 8'd10;
            3'd3:    return 8'd16;
            3'd4:    return 8'd50;
            3'd5:    return 8'd64;
            3'd6:    return 8'd100;
            3'd7:    return 8'd200;
            default: return 8'd4;
        endcase
    endfunction

endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);
    import ptimer_pkg::*;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
    } psc_st_t;

    psc_st_t          st_d, st_q;
    logic [PSC_W-1:0] div_m1;

    always_comb begin
        div_m1 = PSC_W'(prescale_div(sel)) - PSC_W'(1);
        tick   = run && (st_q.psc == div_m1);
        st_d   = st_q;
        if (clr)       st_d.psc = '0;
        else if (tick) st_d.psc = '0;
        else if (run)  st_d.psc = st_q.psc + PSC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ptimer_aux.sv
module ptimer_aux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_in,
    input  logic pol,
    output logic level_on,
    output logic lead,
    output logic trail
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } aux_st_t;

    aux_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[TOP-1:0], aux_in};
        st_d.prev = st_q.sync[TOP];
        level_on  = (st_q.sync[TOP] == pol);
        lead      = level_on && (st_q.prev != pol);
        trail     = !level_on && (st_q.prev == pol);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             tick,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             out_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             timeout,
    output logic             tout
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic out;
        logic tmo;
    } flag_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
    } val_t;

    flag_t fl_d, fl_q;
    val_t  vl_d, vl_q;

    always_comb begin
        vl_d = vl_q;
        fl_d = fl_q;
        if (load_we) vl_d.reload = load_val;
        if (tick) begin
            vl_d.cnt = (vl_q.cnt == ONE) ? vl_q.reload : vl_q.cnt - ONE;
        end else if (load_we && !running) begin
            vl_d.cnt = load_val;
        end
        fl_d.tmo = tick && (vl_q.cnt == ONE);
        if (out_clr)       fl_d.out = 1'b0;
        else if (fl_d.tmo) fl_d.out = !fl_q.out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    always_ff @(posedge clk) begin
        vl_q <= vl_d;
    end

    assign cnt     = vl_q.cnt;
    assign timeout = fl_q.tmo;
    assign tout    = fl_q.out;
endmodule

// File: rtl/ptimer.sv
module ptimer #(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [5:0]       cfg_wdata,
    input  logic             data_we,
    input  logic [CNT_W-1:0] data_wdata,
    input  logic             aux_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tmr_out,
    output logic             timeout_o,
    output logic             aux_evt_o
);
    import ptimer_pkg::*;

    ctrl_t ctrl_d, ctrl_q;
    mode_e mode;
    logic  psc_run, psc_clr, psc_tick, cnt_tick, running;
    logic  level_on, lead, trail, out_clr;

    always_comb begin
        ctrl_d = ctrl_q;
        if (cfg_we) begin
            ctrl_d.field = cfg_wdata[3:0];
            ctrl_d.pol   = cfg_wdata[4];
        end
        mode      = decode_mode(ctrl_q.field);
        running   = (mode != MD_STOP);
        psc_run   = (mode == MD_DELAY) || ((mode == MD_PULSE) && level_on);
        psc_clr   = cfg_we || (mode == MD_STOP) || (mode == MD_EVENT);
        cnt_tick  = (mode == MD_EVENT) ? lead : psc_tick;
        aux_evt_o = (mode == MD_PULSE) ? trail : lead;
        out_clr   = cfg_we && cfg_wdata[5];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    ptimer_aux #(.SYNC_STAGES(SYNC_STAGES)) u_aux (
        .clk(clk), .rst_n(rst_n), .aux_in(aux_in), .pol(ctrl_q.pol),
        .level_on(level_on), .lead(lead), .trail(trail)
    );

    ptimer_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr(psc_clr), .run(psc_run),
        .sel(ctrl_q.field[2:0]), .tick(psc_tick)
    );

    ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .running(running), .tick(cnt_tick),
        .load_we(data_we), .load_val(data_wdata), .out_clr(out_clr),
        .cnt(cnt_o), .timeout(timeout_o), .tout(tmr_out)
    );
endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_req,
    input logic             data_we,
    input logic [CNT_W-1:0] cnt_o,
    input logic             tmr_out,
    input logic             timeout_o
);
    assert_reload_at_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> ($past(cnt_o) == CNT_W'(1)));

    assert_toggle_on_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !$past(clr_req)) |-> (tmr_out != $past(tmr_out)));

    assert_hold_without_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_o && !$past(clr_req)) |-> $stable(tmr_out));

    assert_clear_forces_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_req) |-> !tmr_out);

    // R7 / R9: the count only holds, decrements by one, or is loaded by a write
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!timeout_o && !$past(data_we)) |->
            ((cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) - CNT_W'(1))));
endmodule

bind ptimer ptimer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_req(cfg_we && cfg_wdata[5]),
    .data_we(data_we), .cnt_o(cnt_o), .tmr_out(tmr_out), .timeout_o(timeout_o)
);

// File: tb/sim_ptimer.sv
module sim_ptimer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       aux_in = 1'b0;
    logic [7:0] cnt_o;
    logic       tmr_out, timeout_o, aux_evt_o;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int to_count = 0;
    int evt_count = 0;
    int w = 0;
    bit sb_on = 1'b0;
    string sb_tag = "R2";
    int q[$];

    ptimer u0 (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // scoreboard monitor: time-outs compared against expected cycle numbers
    always @(negedge clk) begin
        if (timeout_o) to_count++;
        if (aux_evt_o) evt_count++;
        if (sb_on && timeout_o) begin
            if (q.size() == 0) check(1'b0, {sb_tag, " unexpected time-out"}, cyc, -1);
            else begin
                int e;
                e = q.pop_front();
                check(cyc == e, {sb_tag, " time-out cycle"}, cyc, e);
            end
        end
    end

    task automatic wr_cfg(input logic [5:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
        w = cyc;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_we = 1'b1; data_wdata = v;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic aux_pulse(input int hi, input int lo);
        @(negedge clk); aux_in = 1'b1;
        wait_n(hi);
        aux_in = 1'b0;
        wait_n(lo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        summary();
        $finish;
    end

    initial begin
        int c0, e0, o;
        wait_n(2);
        wr_data(8'd100);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(1);
        check(tmr_out == 1'b0, "R3 reset output", tmr_out, 0);
        check(timeout_o == 1'b0, "R1 reset time-out", timeout_o, 0);
        check(cnt_o == 8'd100, "R7 stopped load", cnt_o, 100);

        // R4: divisor 10, load 100
        sb_tag = "R4"; sb_on = 1'b1;
        wr_cfg(6'h02);
        q.push_back(w + 1000); q.push_back(w + 2000); q.push_back(w + 3000);
        wait_n(3010);
        check(q.size() == 0, "R4 missing time-outs", q.size(), 0);
        check(tmr_out == 1'b1, "R3 three toggles", tmr_out, 1);
        sb_on = 1'b0;
        wr_cfg(6'h20);
        check(tmr_out == 1'b0, "R3 clear bit", tmr_out, 0);

        // R2: load 1 and load 0
        wr_data(8'd1);
        sb_tag = "R2"; sb_on = 1'b1;
        wr_cfg(6'h01);
        q.push_back(w + 4); q.push_back(w + 8); q.push_back(w + 12);
        wait_n(13);
        check(q.size() == 0, "R2 load one", q.size(), 0);
        check(cnt_o == 8'd1, "R1 reload value", cnt_o, 1);
        sb_on = 1'b0;
        wr_cfg(6'h00);
        wr_data(8'd0);
        sb_on = 1'b1;
        wr_cfg(6'h01);
        q.push_back(w + 1024); q.push_back(w + 2048);
        wait_n(2050);
        check(q.size() == 0, "R2 load zero", q.size(), 0);
        sb_on = 1'b0;
        wr_cfg(6'h00);

        // R7 / R9: write while running
        wr_data(8'd5);
        sb_tag = "R7"; sb_on = 1'b1;
        wr_cfg(6'h01);
        q.push_back(w + 20); q.push_back(w + 32); q.push_back(w + 44);
        wait_n(13);
        check(cnt_o == 8'd2, "R9 live count", cnt_o, 2);
        wr_data(8'd3);
        check(cnt_o == 8'd2, "R7 running write keeps count", cnt_o, 2);
        wait_n(30);
        check(q.size() == 0, "R7 new reload", q.size(), 0);
        sb_on = 1'b0;
        wr_cfg(6'h00);

        // R10: stopped
        c0 = cnt_o; e0 = to_count;
        wait_n(300);
        check(cnt_o == c0, "R10 count holds", cnt_o, c0);
        check(to_count == e0, "R10 no time-out", to_count, e0);

        // R6: event count, polarity high then low
        wr_data(8'd3);
        wr_cfg(6'h18);
        e0 = evt_count;
        aux_pulse(4, 4); aux_pulse(4, 4);
        wait_n(4);
        check(cnt_o == 8'd1, "R6 rising edges counted", cnt_o, 1);
        check(evt_count == e0 + 2, "R6 event strobes", evt_count, e0 + 2);
        c0 = to_count;
        aux_pulse(4, 4);
        wait_n(4);
        check(cnt_o == 8'd3, "R1 event reload", cnt_o, 3);
        check(to_count == c0 + 1, "R1 single time-out", to_count, c0 + 1);
        wr_cfg(6'h08);
        e0 = evt_count;
        aux_pulse(4, 4);
        wait_n(4);
        check(cnt_o == 8'd2, "R6 falling edge only", cnt_o, 2);
        check(evt_count == e0 + 1, "R6 falling strobe", evt_count, e0 + 1);

        // R5: pulse-width window of 30 clocks, divisor 4
        wr_cfg(6'h00);
        wr_data(8'd10);
        wr_cfg(6'h19);
        wait_n(100);
        check(cnt_o == 8'd10, "R5 gate closed", cnt_o, 10);
        e0 = evt_count;
        @(negedge clk); aux_in = 1'b1;
        wait_n(30);
        aux_in = 1'b0;
        wait_n(20);
        check(cnt_o == 8'd3, "R5 gated count", cnt_o, 3);
        check(evt_count == e0 + 1, "R5 trailing strobe only", evt_count, e0 + 1);
        wait_n(50);
        check(cnt_o == 8'd3, "R5 holds after window", cnt_o, 3);

        // R3 toggle, then R8 reset
        wr_cfg(6'h00);
        wr_data(8'd1);
        wr_cfg(6'h18);
        o = tmr_out;
        aux_pulse(4, 4);
        wait_n(4);
        check(tmr_out == !o, "R3 toggle", tmr_out, !o);
        wr_cfg(6'h00);
        wr_data(8'h37);
        wr_cfg(6'h07);
        wait_n(10);
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        check(cnt_o == 8'h37, "R8 count kept", cnt_o, 8'h37);
        check(tmr_out == 1'b0, "R3 reset low", tmr_out, 0);
        c0 = to_count;
        wait_n(500);
        check(cnt_o == 8'h37, "R8 stopped after reset", cnt_o, 8'h37);
        check(to_count == c0, "R8 no time-out", to_count, c0);

        summary();
        $finish;
    end
endmodule